// File: doc/BRIEF.md
# Power-of-Two Scaling Unit

This unit multiplies a binary floating-point value by two raised to a whole number. The whole number comes from a second floating-point operand, truncated toward zero. Both operands use the same layout: a sign bit, an `EW`-bit biased exponent, and an `MW`-bit significand whose top bit is an explicit integer bit. The caller supplies a rounding mode and two mask bits, one for overflow and one for underflow. Each result comes back with five exception flags. Trapping, operand stacks and any conversion of the scale operand other than truncation are handled outside this block.

Operands enter through a valid/ready stream and leave through another valid/ready stream. An operand pair is taken on a clock edge where `in_valid` and `in_ready` are both high. The result is then offered on `out_valid` from the next cycle. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so one result can be taken and one new pair accepted per cycle. While the consumer holds `out_ready` low, the offered result stays unchanged and no new pair is accepted.

Special operands have fixed outcomes. Infinite scale factors give signed zeros, signed infinities or an invalid operation. A scale whose magnitude is too large is clamped before use, and this always lands in overflow or underflow. Overflow and underflow results depend on the masks and on the rounding mode. A masked underflow yields a denormalized result.

Top module: `fsc_pow2_scale`

## Requirements
- R1: Handshake.
  - After reset `out_valid` is 0.
  - A pair accepted on a clock edge shows up as `out_valid`=1 after that edge.
  - While `out_valid`=1 and `out_ready`=0, the result and flags hold steady and `in_ready`=0.
  - Results leave in the order their operands were accepted.
- R2: Exponent arithmetic.
  - For finite nonzero operands, the scale is the integer part of the second operand, truncated toward zero.
  - When the result is in range, its exponent is the first operand's normalized exponent plus that integer, its significand is the normalized significand, and no flags are set.
- R3: NaN inputs.
  - A NaN has an all-ones exponent and a nonzero fraction, where the fraction is significand bits `MW-2:0`. It is quiet when bit `MW-2` is set and signaling otherwise.
  - If either operand is a NaN, the result is that NaN with bit `MW-2` forced to 1. The first operand is taken when both are NaNs.
  - The invalid flag is set only if one of the NaNs is signaling.
- R4: Invalid cases. A zero scaled by either infinity, or an infinity scaled by negative infinity, sets invalid. The result is the default NaN: sign 1, all-ones exponent, top two significand bits 1 and the rest 0.
- R5: A finite nonzero value scaled by negative infinity returns zero with the value's sign. Scaled by positive infinity, it returns infinity with the value's sign: all-ones exponent, significand with only the integer bit set.
- R6: Pass-through cases.
  - An infinite first operand with a finite or positive-infinite scale is returned unchanged.
  - A zero first operand with a finite scale returns a signed zero (all bits but the sign clear).
- R7: An operand with a zero exponent and a nonzero significand raises the denormal flag (flag bit 1) whenever no NaN is present. The first operand is normalized before it is scaled.
- R8: With overflow unmasked (`in_ovf_mask`=0), a result whose biased exponent reaches all ones sets the overflow flag (bit 2). The result is infinity with the operand's sign.
- R9: With overflow masked, overflow sets the overflow and precision (bit 4) flags. The rounding mode encodings are 00 to nearest-even, 01 toward minus infinity, 10 toward plus infinity and 11 toward zero. The result is signed infinity in these cases:
  - round to nearest;
  - rounding toward minus infinity with a negative value;
  - rounding toward plus infinity with a positive value.
  In every other case the result is the largest finite value: exponent all ones minus one, significand all ones.
- R10: With underflow unmasked (`in_unf_mask`=0), a biased exponent of zero or below sets the underflow flag (bit 3) and returns zero with the operand's sign.
- R11: With underflow masked, a tiny result is shifted right into the denormal range and rounded by the selected mode. The exponent field is 1 if rounding sets the integer bit and 0 otherwise. Underflow and precision are set only when bits were lost; an exact denormal result raises neither.
- R12: Clamping. Scale integers of magnitude `2^(EW+1)` or more saturate at that magnitude. Any first operand still overflows or underflows exactly as an unclamped factor would.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Unit can take an operand pair |
| in_val | input | 1+EW+MW | Value to be scaled {sign, exponent, significand} |
| in_scl | input | 1+EW+MW | Scale operand, same layout |
| in_rm | input | 2 | Rounding mode (R9 encoding) |
| in_ovf_mask | input | 1 | 1 = overflow masked |
| in_unf_mask | input | 1 | 1 = underflow masked |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Consumer takes the result |
| out_res | output | 1+EW+MW | Scaled result |
| out_flags | output | 5 | {precision, underflow, overflow, denormal, invalid} |

## Verification
The bench builds the unit with `EW`=5 and `MW`=8, which gives a bias of 15 and a scale clamp at 64. At these widths a random scale operand frequently drives the exponent past either end of the range. Denormal first operands, massive underflows that leave only sticky bits, and rounding that carries back into the integer bit all occur often. Every mask and rounding-mode combination is therefore reached alongside saturation of the scale factor, while random stalls on `out_ready` exercise the hold behaviour.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } fsc_rm_e;

  typedef enum logic [2:0] {
    CL_ZERO,
    CL_FIN,
    CL_INF,
    CL_QNAN,
    CL_SNAN
  } fsc_cls_e;

  localparam int FLG_INV = 0;
  localparam int FLG_DEN = 1;
  localparam int FLG_OVF = 2;
  localparam int FLG_UNF = 3;
  localparam int FLG_PRE = 4;
  localparam int FLG_W   = 5;

endpackage

// File: rtl/fsc_classify.sv
module fsc_classify
  import fsc_pkg::*;
#(
  parameter int EW = 15,
  parameter int MW = 64
) (
  input  logic [EW-1:0] exp_f,
  input  logic [MW-1:0] sig_f,
  output fsc_cls_e      cls,
  output logic          den
);

  logic top_exp;
  logic frac_nz;

  always_comb begin
    top_exp = &exp_f;
    frac_nz = |sig_f[MW-2:0];
    den     = 1'b0;
    if (top_exp) begin
      if (!frac_nz)          cls = CL_INF;
      else if (sig_f[MW-2])  cls = CL_QNAN;
      else                   cls = CL_SNAN;
    end else if (sig_f == '0) begin
      cls = CL_ZERO;
    end else begin
      cls = CL_FIN;
      den = (exp_f == '0);
    end
  end

endmodule

// File: rtl/fsc_normalize.sv
module fsc_normalize #(
  parameter int EW = 15,
  parameter int MW = 64,
  parameter int XW = 19
) (
  input  logic [EW-1:0]        exp_f,
  input  logic [MW-1:0]        sig_f,
  output logic [MW-1:0]        nsig,
  output logic signed [XW-1:0] uexp
);

  localparam int BIAS = (1 << (EW-1)) - 1;
  localparam int LZW  = $clog2(MW+1);

  logic [LZW-1:0] lz;
  logic [EW-1:0]  eff;

  always_comb begin
    lz = '0;
    for (int i = 0; i < MW; i++) begin
      if (sig_f[i]) lz = LZW'(MW-1-i);
    end
    nsig = sig_f << lz;
    eff  = (exp_f == '0) ? EW'(1) : exp_f;
    uexp = XW'(eff) - XW'(BIAS) - XW'(lz);
  end

endmodule

// File: rtl/fsc_scale_int.sv
module fsc_scale_int #(
  parameter int EW = 15,
  parameter int MW = 64,
  parameter int XW = 19
) (
  input  logic                 sgn,
  input  logic [EW-1:0]        exp_f,
  input  logic [MW-1:0]        sig_f,
  output logic signed [XW-1:0] n
);

  localparam int BIAS  = (1 << (EW-1)) - 1;
  localparam int CAPSH = EW + 1;

  int          sh;
  logic [XW-1:0] mag;

  always_comb begin
    sh = int'(exp_f) - BIAS;
    if (sh < 0)            mag = '0;
    else if (sh >= CAPSH)  mag = XW'(1) << CAPSH;
    else                   mag = XW'(sig_f >> (MW-1-sh));
    n = sgn ? -mag : mag;
  end

endmodule

// File: rtl/fsc_round_pack.sv
module fsc_round_pack
  import fsc_pkg::*;
#(
  parameter int EW = 15,
  parameter int MW = 64,
  parameter int XW = 19
) (
  input  logic                 sgn,
  input  logic [MW-1:0]        nsig,
  input  logic signed [XW-1:0] bexp,
  input  logic [1:0]           rm,
  input  logic                 ovf_mask,
  input  logic                 unf_mask,
  output logic [EW+MW:0]       res,
  output logic                 ovf,
  output logic                 unf,
  output logic                 pre
);

  localparam int EMAX = (1 << EW) - 1;
  localparam int EXTW = 2*MW + 2;

  logic [EXTW-1:0] ext;
  int              shr;
  logic [MW-1:0]   kept;
  logic [MW-1:0]   rnd;
  logic            grd, stk, inc, big;

  always_comb begin
    big = (fsc_rm_e'(rm) == RM_NEAR) ||
          (fsc_rm_e'(rm) == RM_DOWN && sgn) ||
          (fsc_rm_e'(rm) == RM_UP && !sgn);
    shr = 1 - int'(bexp);
    if (shr > MW+1) shr = MW+1;
    if (shr < 0)    shr = 0;
    ext  = {nsig, (MW+2)'(0)} >> shr;
    kept = ext[EXTW-1 -: MW];
    grd  = ext[MW+1];
    stk  = |ext[MW:0];
    case (fsc_rm_e'(rm))
      RM_NEAR: inc = grd && (stk || kept[0]);
      RM_DOWN: inc = sgn && (grd || stk);
      RM_UP:   inc = !sgn && (grd || stk);
      default: inc = 1'b0;
    endcase
    rnd = kept + MW'(inc);

    res = {sgn, bexp[EW-1:0], nsig};
    ovf = 1'b0;
    unf = 1'b0;
    pre = 1'b0;
    if (bexp >= EMAX) begin
      ovf = 1'b1;
      if (!ovf_mask || big) res = {sgn, {EW{1'b1}}, 1'b1, {(MW-1){1'b0}}};
      else                  res = {sgn, {(EW-1){1'b1}}, 1'b0, {MW{1'b1}}};
      pre = ovf_mask;
    end else if (bexp <= 0) begin
      if (!unf_mask) begin
        unf = 1'b1;
        res = {sgn, {(EW+MW){1'b0}}};
      end else begin
        unf = grd || stk;
        pre = grd || stk;
        res = {sgn, {(EW-1){1'b0}}, rnd[MW-1], rnd};
      end
    end
  end

endmodule

// File: rtl/fsc_pow2_scale.sv
module fsc_pow2_scale
  import fsc_pkg::*;
#(
  parameter int EW = 15,
  parameter int MW = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [EW+MW:0]       in_val,
  input  logic [EW+MW:0]       in_scl,
  input  logic [1:0]           in_rm,
  input  logic                 in_ovf_mask,
  input  logic                 in_unf_mask,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [EW+MW:0]       out_res,
  output logic [FLG_W-1:0]     out_flags
);

  localparam int W    = 1 + EW + MW;
  localparam int BIAS = (1 << (EW-1)) - 1;
  localparam int XW   = ((EW > $clog2(MW+1)) ? EW : $clog2(MW+1)) + 4;
  localparam logic [W-1:0] QBIT = W'(1) << (MW-2);
  localparam logic [W-1:0] DNAN = {1'b1, {EW{1'b1}}, 2'b11, {(MW-2){1'b0}}};

  logic [W-1:0]  opnd    [2];
  fsc_cls_e      op_cls  [2];
  logic          op_den  [2];

  assign opnd[0] = in_val;
  assign opnd[1] = in_scl;

  for (genvar g = 0; g < 2; g++) begin : g_cls
    fsc_classify #(.EW(EW), .MW(MW)) u_cls (
      .exp_f (opnd[g][W-2:MW]),
      .sig_f (opnd[g][MW-1:0]),
      .cls   (op_cls[g]),
      .den   (op_den[g])
    );
  end

  logic [MW-1:0]        a_nsig;
  logic signed [XW-1:0] a_uexp;
  logic signed [XW-1:0] scl_n;
  logic signed [XW-1:0] scl_eff;
  logic signed [XW-1:0] bexp;

  fsc_normalize #(.EW(EW), .MW(MW), .XW(XW)) u_norm (
    .exp_f (in_val[W-2:MW]),
    .sig_f (in_val[MW-1:0]),
    .nsig  (a_nsig),
    .uexp  (a_uexp)
  );

  fsc_scale_int #(.EW(EW), .MW(MW), .XW(XW)) u_sint (
    .sgn   (in_scl[W-1]),
    .exp_f (in_scl[W-2:MW]),
    .sig_f (in_scl[MW-1:0]),
    .n     (scl_n)
  );

  assign scl_eff = (op_cls[1] == CL_ZERO) ? '0 : scl_n;
  assign bexp    = a_uexp + scl_eff + XW'(BIAS);

  logic [W-1:0] rp_res;
  logic         rp_ovf, rp_unf, rp_pre;

  fsc_round_pack #(.EW(EW), .MW(MW), .XW(XW)) u_rp (
    .sgn      (in_val[W-1]),
    .nsig     (a_nsig),
    .bexp     (bexp),
    .rm       (in_rm),
    .ovf_mask (in_ovf_mask),
    .unf_mask (in_unf_mask),
    .res      (rp_res),
    .ovf      (rp_ovf),
    .unf      (rp_unf),
    .pre      (rp_pre)
  );

  logic             a_nan, b_nan, any_snan;
  logic [W-1:0]     nxt_res;
  logic [FLG_W-1:0] nxt_flg;

  always_comb begin
    a_nan    = (op_cls[0] == CL_QNAN) || (op_cls[0] == CL_SNAN);
    b_nan    = (op_cls[1] == CL_QNAN) || (op_cls[1] == CL_SNAN);
    any_snan = (op_cls[0] == CL_SNAN) || (op_cls[1] == CL_SNAN);
    nxt_res  = '0;
    nxt_flg  = '0;
    if (a_nan || b_nan) begin
      nxt_flg[FLG_INV] = any_snan;
      nxt_res = (a_nan ? in_val : in_scl) | QBIT;
    end else begin
      nxt_flg[FLG_DEN] = op_den[0] || op_den[1];
      if (op_cls[1] == CL_INF) begin
        if (op_cls[0] == CL_ZERO || (op_cls[0] == CL_INF && in_scl[W-1])) begin
          nxt_flg[FLG_INV] = 1'b1;
          nxt_res = DNAN;
        end else if (op_cls[0] == CL_INF) begin
          nxt_res = in_val;
        end else if (in_scl[W-1]) begin
          nxt_res = {in_val[W-1], {(W-1){1'b0}}};
        end else begin
          nxt_res = {in_val[W-1], {EW{1'b1}}, 1'b1, {(MW-1){1'b0}}};
        end
      end else if (op_cls[0] == CL_INF) begin
        nxt_res = in_val;
      end else if (op_cls[0] == CL_ZERO) begin
        nxt_res = {in_val[W-1], {(W-1){1'b0}}};
      end else begin
        nxt_res = rp_res;
        nxt_flg[FLG_OVF] = rp_ovf;
        nxt_flg[FLG_UNF] = rp_unf;
        nxt_flg[FLG_PRE] = rp_pre;
      end
    end
  end

  logic in_fire;
  assign in_ready = !out_valid || out_ready;
  assign in_fire  = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
      out_flags <= '0;
    end else begin
      if (in_fire) begin
        out_valid <= 1'b1;
        out_res   <= nxt_res;
        out_flags <= nxt_flg;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R1
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_res) && $stable(out_flags));

  // R1
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R3
  nan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (&out_res[W-2:MW]) && (|out_res[MW-2:0]) |-> out_res[MW-2]);

  // R8
  ovf_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flags[FLG_OVF] && !out_flags[FLG_PRE]
    |-> (&out_res[W-2:MW]) && (out_res[MW-2:0] == '0));

  // R10
  unf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flags[FLG_UNF] && !out_flags[FLG_PRE] |-> out_res[W-2:0] == '0);

  // R11
  unf_tiny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flags[FLG_UNF] && out_flags[FLG_PRE] |-> out_res[W-2:MW] <= EW'(1));

endmodule

// File: tb/tb_fsc_pow2_scale.sv
module tb_fsc_pow2_scale;

  localparam int EW   = 5;
  localparam int MW   = 8;
  localparam int W    = 1 + EW + MW;
  localparam int BIAS = (1 << (EW-1)) - 1;
  localparam int EMAX = (1 << EW) - 1;
  localparam int CAP  = 1 << (EW+1);

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [1:0]   rm;
    logic         om;
    logic         um;
  } stim_t;

  typedef struct {
    logic [W-1:0] r;
    logic [4:0]   f;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_val = '0;
  logic [W-1:0] in_scl = '0;
  logic [1:0]   in_rm = '0;
  logic         in_ovf_mask = 1'b0;
  logic         in_unf_mask = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [W-1:0] out_res;
  logic [4:0]   out_flags;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit in_took = 0;
  bit held = 0;
  logic [W-1:0] held_res;
  logic [4:0]   held_flg;
  stim_t stim_q[$];
  exp_t  exp_q[$];

  always #10 clk = ~clk;

  fsc_pow2_scale #(.EW(EW), .MW(MW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_val(in_val), .in_scl(in_scl), .in_rm(in_rm),
    .in_ovf_mask(in_ovf_mask), .in_unf_mask(in_unf_mask),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_res(out_res), .out_flags(out_flags)
  );

  function automatic logic [W-1:0] mk(input logic s, input int e, input int m);
    return {s, EW'(e), MW'(m)};
  endfunction

  function automatic void ref_model(input logic [W-1:0] a, input logic [W-1:0] b,
                                    input logic [1:0] rm, input logic om, input logic um,
                                    output logic [W-1:0] r, output logic [4:0] f,
                                    output string tag);
    logic sa, sb, a_nan, b_nan, a_inf, b_inf, a_zero, b_zero, den, g, st, up;
    int ea, eb, n, sh, e;
    logic [MW-1:0] ma, mb, m;
    logic [W-1:0] inf_v;
    sa = a[W-1]; sb = b[W-1];
    ea = int'(a[W-2:MW]); eb = int'(b[W-2:MW]);
    ma = a[MW-1:0]; mb = b[MW-1:0];
    a_nan  = (ea == EMAX) && (ma[MW-2:0] != 0);
    b_nan  = (eb == EMAX) && (mb[MW-2:0] != 0);
    a_inf  = (ea == EMAX) && (ma[MW-2:0] == 0);
    b_inf  = (eb == EMAX) && (mb[MW-2:0] == 0);
    a_zero = (ea != EMAX) && (ma == 0);
    b_zero = (eb != EMAX) && (mb == 0);
    den    = (ea == 0 && ma != 0) || (eb == 0 && mb != 0);
    inf_v  = {sa, {EW{1'b1}}, 1'b1, {(MW-1){1'b0}}};
    f = '0;
    tag = "R2";
    if (a_nan || b_nan) begin
      f[0] = (a_nan && !ma[MW-2]) || (b_nan && !mb[MW-2]);
      r = a_nan ? a : b;
      r[MW-2] = 1'b1;
      tag = "R3";
      return;
    end
    f[1] = den;
    if (b_inf) begin
      if (a_zero || (a_inf && sb)) begin
        f[0] = 1'b1; r = {1'b1, {EW{1'b1}}, 2'b11, {(MW-2){1'b0}}}; tag = "R4";
      end else if (a_inf) begin
        r = a; tag = "R6";
      end else begin
        r = sb ? {sa, {(W-1){1'b0}}} : inf_v; tag = "R5";
      end
    end else if (a_inf) begin
      r = a; tag = "R6";
    end else if (a_zero) begin
      r = {sa, {(W-1){1'b0}}}; tag = "R6";
    end else begin
      n = 0;
      if (!b_zero && eb != 0) begin
        sh = eb - BIAS;
        if (sh >= EW+1) begin n = CAP; tag = "R12"; end
        else if (sh >= 0) n = int'(mb) / (1 << (MW-1-sh));
        if (sb) n = -n;
      end
      m = ma; e = (ea == 0) ? 1 : ea;
      while (!m[MW-1]) begin m = m << 1; e = e - 1; end
      e = e + n;
      if (e >= EMAX) begin
        f[2] = 1'b1;
        if (tag != "R12") tag = om ? "R9" : "R8";
        up = (rm == 2'b00) || (rm == 2'b01 && sa) || (rm == 2'b10 && !sa);
        if (!om || up) r = inf_v;
        else r = {sa, EW'(EMAX-1), {MW{1'b1}}};
        f[4] = om;
      end else if (e <= 0) begin
        if (tag != "R12") tag = um ? "R11" : "R10";
        if (!um) begin
          f[3] = 1'b1; r = {sa, {(W-1){1'b0}}};
        end else begin
          g = 0; st = 0;
          for (int k = e; k <= 0; k++) begin
            st = st | g; g = m[0]; m = m >> 1;
          end
          case (rm)
            2'b00: up = g && (st || m[0]);
            2'b01: up = sa && (g || st);
            2'b10: up = !sa && (g || st);
            default: up = 1'b0;
          endcase
          m = m + MW'(up);
          f[3] = g || st; f[4] = g || st;
          r = {sa, EW'(m[MW-1] ? 1 : 0), m};
        end
      end else begin
        r = {sa, EW'(e), m};
      end
    end
    if (den) tag = "R7";
  endfunction

  task automatic push(input logic [W-1:0] a, input logic [W-1:0] b,
                      input int rm, input bit om, input bit um);
    stim_t s;
    s.a = a; s.b = b; s.rm = 2'(rm); s.om = om; s.um = um;
    stim_q.push_back(s);
  endtask

  function automatic logic [W-1:0] rnd_a();
    int e, m;
    case ($urandom_range(0, 9))
      0, 1: e = 0;
      2:    e = EMAX;
      default: e = $urandom_range(1, EMAX-1);
    endcase
    m = $urandom_range(0, (1 << MW) - 1);
    if (e != 0 && e != EMAX && $urandom_range(0, 9) != 0) m = m | (1 << (MW-1));
    return mk(1'($urandom_range(0, 1)), e, m);
  endfunction

  function automatic logic [W-1:0] rnd_b();
    int e;
    case ($urandom_range(0, 9))
      0: e = 0;
      1: e = EMAX;
      2: e = $urandom_range(0, EMAX);
      default: e = $urandom_range(BIAS, BIAS + EW + 2);
    endcase
    return mk(1'($urandom_range(0, 1)), e, $urandom_range(0, (1 << MW) - 1));
  endfunction

  // monitor: samples 5 ns after the falling edge, 5 ns before the rising edge
  always begin
    @(negedge clk);
    #5;
    if (rst_n && !done) begin
      if (held) begin
        checks++;
        if (!out_valid || out_res !== held_res || out_flags !== held_flg) begin
          errors++;
          $display("FAIL R1 hold: got %h/%b valid %b, expected %h/%b valid 1",
                   out_res, out_flags, out_valid, held_res, held_flg);
        end
      end
      held = out_valid && !out_ready;
      held_res = out_res;
      held_flg = out_flags;
      if (out_valid && out_ready) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R1 unexpected result %h, expected none", out_res);
        end else begin
          exp_t x;
          x = exp_q.pop_front();
          if (out_res !== x.r || out_flags !== x.f) begin
            errors++;
            $display("FAIL %s res %h flags %b, expected res %h flags %b",
                     x.tag, out_res, out_flags, x.r, x.f);
          end
        end
      end
      in_took = in_valid && in_ready;
      if (in_took) begin
        exp_t x;
        ref_model(in_val, in_scl, in_rm, in_ovf_mask, in_unf_mask, x.r, x.f, x.tag);
        exp_q.push_back(x);
      end
    end
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog: got no completion, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [W-1:0] one, pinf, ninf;
    int sent;
    one  = mk(0, BIAS, 8'h80);
    pinf = mk(0, EMAX, 8'h80);
    ninf = mk(1, EMAX, 8'h80);
    // R2 exact scaling, positive and negative truncated factors
    push(one, mk(0, 16, 8'he0), 0, 0, 0);
    push(mk(1, 17, 8'ha5), mk(1, 16, 8'hb9), 0, 0, 0);
    // R3 signalling and quiet NaN
    push(mk(0, EMAX, 8'h81), one, 0, 0, 0);
    push(one, mk(1, EMAX, 8'hc0), 0, 0, 0);
    // R4 invalid combinations
    push(mk(0, 0, 0), pinf, 0, 0, 0);
    push(mk(1, 0, 0), ninf, 0, 0, 0);
    push(pinf, ninf, 0, 0, 0);
    // R5 infinite factors on finite values
    push(mk(1, BIAS, 8'hc0), ninf, 0, 0, 0);
    push(mk(0, BIAS, 8'hc0), pinf, 0, 0, 0);
    // R6 pass-through
    push(pinf, mk(0, 17, 8'ha0), 0, 0, 0);
    push(mk(1, 0, 0), mk(0, 17, 8'he0), 0, 0, 0);
    // R7 denormal first operand
    push(mk(0, 0, 8'h10), mk(0, 18, 8'h80), 0, 0, 0);
    // R8 unmasked overflow
    push(one, mk(0, 19, 8'ha0), 0, 0, 0);
    // R9 masked overflow in every mode, both signs
    for (int rm = 0; rm < 4; rm++) begin
      push(mk(1, BIAS, 8'h80), mk(0, 19, 8'ha0), rm, 1, 0);
      push(one, mk(0, 19, 8'ha0), rm, 1, 0);
    end
    // R10 unmasked underflow
    push(one, mk(1, 19, 8'ha0), 0, 0, 0);
    // R11 exact and inexact denormal results
    push(mk(0, BIAS, 8'hc0), mk(1, 18, 8'hf0), 0, 0, 1);
    push(mk(0, BIAS, 8'h81), mk(1, 18, 8'hf0), 0, 0, 1);
    push(mk(0, BIAS, 8'h81), mk(1, 18, 8'hf0), 2, 0, 1);
    push(mk(0, BIAS, 8'hff), mk(1, 18, 8'hf0), 0, 0, 1);
    // R12 clamped factors
    push(one, mk(0, 30, 8'hff), 3, 1, 0);
    push(one, mk(1, 30, 8'hff), 2, 0, 1);
    push(one, mk(1, 30, 8'hff), 0, 0, 1);
    for (int i = 0; i < 3000; i++)
      push(rnd_a(), rnd_b(), $urandom_range(0, 3), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #5;
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1 reset: out_valid %b in_ready %b, expected 0 1", out_valid, in_ready);
    end

    sent = 0;
    while (sent < stim_q.size()) begin
      @(negedge clk);
      if (in_took) begin
        in_valid = 1'b0;
        sent++;
      end
      out_ready = ($urandom_range(0, 3) != 0);
      if (!in_valid && sent < stim_q.size() && $urandom_range(0, 4) != 0) begin
        in_val      = stim_q[sent].a;
        in_scl      = stim_q[sent].b;
        in_rm       = stim_q[sent].rm;
        in_ovf_mask = stim_q[sent].om;
        in_unf_mask = stim_q[sent].um;
        in_valid    = 1'b1;
      end
    end
    out_ready = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R1 drain: %0d results outstanding, expected 0", exp_q.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule